// File: doc/BRIEF.md
# Transmit Self-Test Character Generator

This block sits in front of one transmit channel's character encoder. While its enable bit is clear it passes the user byte and 2-bit control code to the encoder through one register stage. Once the enable bit is set over the configuration port, the user inputs are ignored. The block then emits a repeating pass of pseudo-random characters taken from a 9-bit maximal-length shift register. A checker at the far end that runs the same register can verify every character it receives.

A pass can begin with a burst of 16 word-sync characters, which gives a far-end elasticity buffer a pattern to align on. The `sync_mode` input chooses this variant, and the block samples it once at the first character of each pass. A one-cycle marker flags the first character of every pass. The pattern deliberately includes data characters, special characters and code-violation requests, so the receive checker exercises every class of symbol.

Top module: `txbist_gen`

## Requirements
- R1: While `rst_n` is low, `tx_data`, `tx_ctl` and `tx_pass_start` are 0 and the enable bit is cleared. After reset the block passes user data until the enable bit is written to 1.
- R2: While the enable bit is clear, `tx_data`/`tx_ctl` at a clock edge equal `usr_data`/`usr_ctl` sampled at that same edge, so they appear one cycle after being driven. In this state `tx_pass_start` is 0.
- R3: A write (`cfg_we`=1) with `cfg_bist_en`=1 while disabled sets the enable bit at edge t. The first character of a pass, with `tx_pass_start`=1, is then output at edge t+1.
- R4: Pattern characters come from a state s (9 bits) that starts at 0x1FF and advances as s <= {s[7:0], s[8]^s[4]} after each pattern character. `tx_data` = s[7:0]. `tx_ctl` = 2'b00 (data) when s[8]=1, 2'b01 (special) when s[8]=0 and s[7]=1, and 2'b10 (violation) otherwise.
- R5: A pass without sync prefix is 511 characters long. Its data characters cover all 256 byte values, and it holds 128 special and 127 violation characters.
- R6: When `sync_mode` is 1 at the first character of a pass, the pass is 526 characters long. It opens with 16 characters of `tx_ctl`=2'b11 and `tx_data`=0xBC, followed by the first 510 pattern characters of R4 starting from 0x1FF.
- R7: Passes follow one another with no gap, and each pass starts from state 0x1FF. `sync_mode` is sampled only at the first character of each pass, so a change in the middle of a pass affects only the next pass.
- R8: While the enable bit is set, `usr_data` and `usr_ctl` have no effect on any output.
- R9: Writing the enable bit to 1 while it is already set neither restarts nor disturbs the pass in progress.
- R10: A write with `cfg_bist_en`=0 at edge t clears the enable bit. The output at edge t+1 is the user character sampled at edge t+1. The next enable starts a fresh pass.
- R11: `tx_pass_start` is 1 only on the first character of a pass and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| cfg_we | input | 1 | Configuration write strobe for the enable bit |
| cfg_bist_en | input | 1 | Value written to the enable bit |
| sync_mode | input | 1 | 1: each pass begins with a 16-character sync burst |
| usr_data | input | 8 | User character byte |
| usr_ctl | input | 2 | User character control code |
| tx_data | output | 8 | Byte to the encoder |
| tx_ctl | output | 2 | Control code to the encoder (00 data, 01 special, 10 violation, 11 sync) |
| tx_pass_start | output | 1 | High on the first character of each pass |

## Verification
The bench aims at the pass boundaries. A generator that does not reload its state or miscounts its length drifts from the reference model at the 511th or 526th character, and the pass-start gaps come out wrong. It changes `sync_mode` in the middle of a pass, so a design that samples the mode continuously shortens or lengthens the running pass. It rewrites the enable bit while a pass is running, so a design that restarts on every write shows a stray pass-start. It also randomises the user inputs throughout, so any leak of user data into the pattern shows up as a mismatch with the model.

// File: rtl/txbist_pkg.sv
package txbist_pkg;

  typedef enum logic [1:0] {
    GEN_START = 2'd0,
    GEN_SYNC  = 2'd1,
    GEN_PRBS  = 2'd2
  } gen_state_e;

  localparam logic [1:0] CTL_DATA = 2'b00;
  localparam logic [1:0] CTL_SPEC = 2'b01;
  localparam logic [1:0] CTL_VIOL = 2'b10;
  localparam logic [1:0] CTL_SYNC = 2'b11;

endpackage

// File: rtl/txbist_en_latch.sv
module txbist_en_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_val,
  output logic en_q
);

  logic en_d;

  always_comb begin
    en_d = en_q;
    if (cfg_we) en_d = cfg_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

endmodule

// File: rtl/txbist_seq.sv
module txbist_seq
  import txbist_pkg::*;
#(
  parameter int               LFSR_W    = 9,
  parameter int               TAP       = 5,
  parameter int               DATA_W    = 8,
  parameter int               SYNC_LEN  = 16,
  parameter logic [LFSR_W-1:0] SEED     = '1,
  parameter logic [DATA_W-1:0] SYNC_BYTE = 8'hBC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              sync_mode,
  output logic [DATA_W-1:0] gen_data,
  output logic [1:0]        gen_ctl,
  output logic              gen_first
);

  localparam int PASS_LEN = (1 << LFSR_W) - 1;
  localparam int CNT_W    = $clog2(PASS_LEN + SYNC_LEN);
  localparam logic [CNT_W-1:0] LAST_PLAIN  = CNT_W'(PASS_LEN - 1);
  localparam logic [CNT_W-1:0] LAST_SYNCED = CNT_W'(PASS_LEN - 2);
  localparam logic [CNT_W-1:0] SYNC_LAST   = CNT_W'(SYNC_LEN - 1);

  gen_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LFSR_W-1:0] lfsr_q, lfsr_d, src;
  logic              psync_q, psync_d;
  logic              emit_sync;

  function automatic logic [LFSR_W-1:0] step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[TAP-1]};
  endfunction

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    lfsr_d    = lfsr_q;
    psync_d   = psync_q;
    src       = lfsr_q;
    gen_first = 1'b0;
    emit_sync = 1'b0;
    unique case (st_q)
      GEN_START: begin
        gen_first = 1'b1;
        psync_d   = sync_mode;
        src       = SEED;
        cnt_d     = CNT_W'(1);
        if (sync_mode) begin
          emit_sync = 1'b1;
          st_d      = GEN_SYNC;
        end else begin
          lfsr_d = step(SEED);
          st_d   = GEN_PRBS;
        end
      end
      GEN_SYNC: begin
        emit_sync = 1'b1;
        if (cnt_q == SYNC_LAST) begin
          cnt_d  = '0;
          lfsr_d = SEED;
          st_d   = GEN_PRBS;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      GEN_PRBS: begin
        lfsr_d = step(lfsr_q);
        if (cnt_q == (psync_q ? LAST_SYNCED : LAST_PLAIN)) begin
          cnt_d = '0;
          st_d  = GEN_START;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = GEN_START;
    endcase
    if (!run) begin
      st_d    = GEN_START;
      cnt_d   = '0;
      lfsr_d  = SEED;
      psync_d = 1'b0;
    end
  end

  always_comb begin
    if (emit_sync) begin
      gen_data = SYNC_BYTE;
      gen_ctl  = CTL_SYNC;
    end else begin
      gen_data = src[DATA_W-1:0];
      if (src[LFSR_W-1])      gen_ctl = CTL_DATA;
      else if (src[DATA_W-1]) gen_ctl = CTL_SPEC;
      else                    gen_ctl = CTL_VIOL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= GEN_START;
      cnt_q   <= '0;
      lfsr_q  <= SEED;
      psync_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      lfsr_q  <= lfsr_d;
      psync_q <= psync_d;
    end
  end

endmodule

// File: rtl/txbist_out_stage.sv
module txbist_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DATA_W-1:0] gen_data,
  input  logic [1:0]        gen_ctl,
  input  logic              gen_first,
  input  logic [DATA_W-1:0] usr_data,
  input  logic [1:0]        usr_ctl,
  output logic [DATA_W-1:0] tx_data,
  output logic [1:0]        tx_ctl,
  output logic              tx_pass_start
);

  logic [DATA_W-1:0] data_d;
  logic [1:0]        ctl_d;
  logic              first_d;

  always_comb begin
    if (run) begin
      data_d  = gen_data;
      ctl_d   = gen_ctl;
      first_d = gen_first;
    end else begin
      data_d  = usr_data;
      ctl_d   = usr_ctl;
      first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data       <= '0;
      tx_ctl        <= '0;
      tx_pass_start <= 1'b0;
    end else begin
      tx_data       <= data_d;
      tx_ctl        <= ctl_d;
      tx_pass_start <= first_d;
    end
  end

endmodule

// File: rtl/txbist_gen.sv
module txbist_gen
  import txbist_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LFSR_W   = 9,
  parameter int TAP      = 5,
  parameter int SYNC_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_bist_en,
  input  logic              sync_mode,
  input  logic [DATA_W-1:0] usr_data,
  input  logic [1:0]        usr_ctl,
  output logic [DATA_W-1:0] tx_data,
  output logic [1:0]        tx_ctl,
  output logic              tx_pass_start
);

  logic              bist_run;
  logic [DATA_W-1:0] gen_data;
  logic [1:0]        gen_ctl;
  logic              gen_first;

  txbist_en_latch u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_val (cfg_bist_en),
    .en_q    (bist_run)
  );

  txbist_seq #(
    .LFSR_W   (LFSR_W),
    .TAP      (TAP),
    .DATA_W   (DATA_W),
    .SYNC_LEN (SYNC_LEN)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (bist_run),
    .sync_mode (sync_mode),
    .gen_data  (gen_data),
    .gen_ctl   (gen_ctl),
    .gen_first (gen_first)
  );

  txbist_out_stage #(
    .DATA_W (DATA_W)
  ) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (bist_run),
    .gen_data      (gen_data),
    .gen_ctl       (gen_ctl),
    .gen_first     (gen_first),
    .usr_data      (usr_data),
    .usr_ctl       (usr_ctl),
    .tx_data       (tx_data),
    .tx_ctl        (tx_ctl),
    .tx_pass_start (tx_pass_start)
  );

endmodule

// File: rtl/txbist_gen_chk.sv
module txbist_gen_chk
  import txbist_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_bist_en,
  input logic              run,
  input logic [DATA_W-1:0] usr_data,
  input logic [1:0]        usr_ctl,
  input logic [DATA_W-1:0] tx_data,
  input logic [1:0]        tx_ctl,
  input logic              tx_pass_start
);

  logic gen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gen_q <= 1'b0;
    else        gen_q <= run;
  end

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (tx_data == $past(usr_data) && tx_ctl == $past(usr_ctl) && !tx_pass_start));

  // R3
  enable_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_bist_en && !run) |=> ##1 tx_pass_start);

  // R4
  spec_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q && tx_ctl == CTL_SPEC) |-> tx_data[DATA_W-1]);

  // R4
  viol_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q && tx_ctl == CTL_VIOL) |-> (!tx_data[DATA_W-1] && tx_data != '0));

  // R6
  sync_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q && tx_pass_start && tx_ctl == CTL_SYNC) |=> (tx_ctl == CTL_SYNC));

  // R10
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_bist_en) |=> ##1 (tx_data == $past(usr_data) && tx_ctl == $past(usr_ctl)));

  // R11
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pass_start |=> !tx_pass_start);

  // R11
  pulse_gen_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pass_start |-> gen_q);

endmodule

bind txbist_gen txbist_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_we        (cfg_we),
  .cfg_bist_en   (cfg_bist_en),
  .run           (bist_run),
  .usr_data      (usr_data),
  .usr_ctl       (usr_ctl),
  .tx_data       (tx_data),
  .tx_ctl        (tx_ctl),
  .tx_pass_start (tx_pass_start)
);

// File: tb/txbist_gen_tb.sv
module txbist_gen_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic       cfg_bist_en;
  logic       sync_mode;
  logic [7:0] usr_data;
  logic [1:0] usr_ctl;
  logic [7:0] tx_data;
  logic [1:0] tx_ctl;
  logic       tx_pass_start;

  txbist_gen u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_bist_en   (cfg_bist_en),
    .sync_mode     (sync_mode),
    .usr_data      (usr_data),
    .usr_ctl       (usr_ctl),
    .tx_data       (tx_data),
    .tx_ctl        (tx_ctl),
    .tx_pass_start (tx_pass_start)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk  = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_en, m_pos, m_sync, m_lfsr;
  int exp_d, exp_c, exp_p;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_pos = 0; m_sync = 0; m_lfsr = 511;
      exp_d = 0; exp_c = 0; exp_p = 0;
    end else begin
      if (m_en == 0) begin
        exp_d = usr_data; exp_c = usr_ctl; exp_p = 0; m_pos = 0;
      end else begin
        int nsync, plen, fb;
        if (m_pos == 0) begin
          m_sync = sync_mode;
          m_lfsr = 511;
        end
        exp_p = (m_pos == 0);
        nsync = m_sync ? 16 : 0;
        plen  = m_sync ? 526 : 511;
        if (m_pos < nsync) begin
          exp_c = 3; exp_d = 8'hBC;
        end else begin
          exp_d = m_lfsr % 256;
          if (m_lfsr >= 256)      exp_c = 0;
          else if (m_lfsr >= 128) exp_c = 1;
          else                    exp_c = 2;
          fb = ((m_lfsr >> 8) ^ (m_lfsr >> 4)) & 1;
          m_lfsr = ((m_lfsr << 1) & 511) | fb;
        end
        m_pos = (m_pos + 1 == plen) ? 0 : m_pos + 1;
      end
      if (cfg_we) m_en = cfg_bist_en;
    end
  end

  // compare on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, {tx_pass_start, tx_ctl, tx_data}, {exp_p[0], exp_c[1:0], exp_d[7:0]},
            "model compare {start,ctl,data}");
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit seen[256];
    int n_data, n_spec, n_viol, gap;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_bist_en = 1'b0; sync_mode = 1'b0;
    usr_data = 8'h00; usr_ctl = 2'b00;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", tx_data, 0, "tx_data in reset");
    check("R1", tx_ctl, 0, "tx_ctl in reset");
    check("R1", tx_pass_start, 0, "pass_start in reset");
    rst_n = 1'b1;

    cur_req = "R2";
    repeat (20) begin
      @(negedge clk);
      usr_data = 8'($urandom); usr_ctl = 2'($urandom);
    end

    // R3: enable
    @(negedge clk); cfg_we = 1'b1; cfg_bist_en = 1'b1; cur_req = "R3";
    @(negedge clk); cfg_we = 1'b0;
    @(negedge clk);
    check("R3", tx_pass_start, 1, "first pass start");
    check("R4", {tx_ctl, tx_data}, {2'b00, 8'hFF}, "first pattern char");
    cur_req = "R8";
    n_data = 0; n_spec = 0; n_viol = 0;
    for (int i = 0; i < 511; i++) begin
      if (i > 0) @(negedge clk);
      if (tx_ctl == 2'b00) begin
        if (!seen[tx_data]) n_data++;
        seen[tx_data] = 1'b1;
      end else if (tx_ctl == 2'b01) n_spec++;
      else if (tx_ctl == 2'b10) n_viol++;
      usr_data = 8'($urandom); usr_ctl = 2'($urandom);
    end
    check("R5", n_data, 256, "distinct data bytes");
    check("R5", n_spec, 128, "special count");
    check("R5", n_viol, 127, "violation count");
    @(negedge clk);
    check("R7", tx_pass_start, 1, "second pass start after 511");
    check("R7", {tx_ctl, tx_data}, {2'b00, 8'hFF}, "second pass reloads seed");

    // R9: enable rewrite while running
    repeat (100) @(negedge clk);
    cur_req = "R9";
    cfg_we = 1'b1; cfg_bist_en = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R9", tx_pass_start, 0, "no restart on re-enable");
    end

    // R6: sync mode, changed mid-pass
    cur_req = "R6";
    sync_mode = 1'b1;
    gap = 0;
    while (!tx_pass_start && gap < 600) begin @(negedge clk); gap++; end
    check("R7", gap, 511 - 104, "pass boundary unaffected by mid-pass mode change");
    check("R6", {tx_ctl, tx_data}, {2'b11, 8'hBC}, "sync burst char");
    sync_mode = 1'b0;
    for (int i = 1; i < 17; i++) begin
      @(negedge clk);
      if (i == 15) check("R6", tx_ctl, 3, "last sync char");
      if (i == 16) check("R6", {tx_ctl, tx_data}, {2'b00, 8'hFF}, "pattern after sync");
    end
    gap = 16;
    while (!tx_pass_start && gap < 700) begin @(negedge clk); gap++; end
    check("R6", gap, 526, "sync pass length");
    check("R7", tx_ctl, 0, "next pass uses new mode");

    // R10: disable
    repeat (40) @(negedge clk);
    cur_req = "R10";
    cfg_we = 1'b1; cfg_bist_en = 1'b0;
    @(negedge clk); cfg_we = 1'b0; usr_data = 8'h5A; usr_ctl = 2'b10;
    @(negedge clk);
    check("R10", {tx_pass_start, tx_ctl, tx_data}, {1'b0, 2'b10, 8'h5A}, "user char after disable");
    repeat (5) @(negedge clk);
    cfg_we = 1'b1; cfg_bist_en = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    @(negedge clk);
    check("R10", tx_pass_start, 1, "fresh pass after re-enable");

    // R1: reset while running clears the enable bit
    repeat (30) @(negedge clk);
    cur_req = "R1";
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {tx_pass_start, tx_ctl, tx_data}, 0, "outputs cleared by reset");
    @(negedge clk);
    usr_data = 8'hC3; usr_ctl = 2'b01;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {tx_pass_start, tx_ctl, tx_data}, {1'b0, 2'b01, 8'hC3}, "user path after reset");
    repeat (10) begin
      @(negedge clk);
      usr_data = 8'($urandom); usr_ctl = 2'($urandom);
    end
    @(negedge clk);
    summary();
    $finish;
  end

endmodule